// File: doc/BRIEF.md
# Out-of-Order Load Ordering Monitor

This block is the load-tracking queue of a core that lets loads execute ahead of older loads. Each load takes a slot when it enters the core and gets that slot number as its tag. When the load executes, it reports its tag and address. The block records which slots have executed and which addresses they read. It also watches invalidation snoops that other processors send to the local cache. A snoop that lands on the line of a load that has already executed marks that load: the value it read may since have been replaced.

An older load to the same line may execute after such a marked younger load. That sequence breaks processor ordering, because the younger load observed memory ahead of the older one. The block detects this case and raises a one-cycle flush request. The request carries the older load's tag, and the core restarts from that load. Every slot from that tag to the tail is freed.

The core retires loads strictly in order. The oldest load may retire only once it has executed. A load becomes oldest only after every older load has retired, so it can no longer be part of a violation.

Top module: `lq_order_monitor`

## Requirements
- R1: After reset the queue is empty: `alloc_ready_o`=1, `alloc_tag_o`=0, `retire_ok_o`=0, `flush_o`=0.
- R2: Tags are handed out in ring order 0,1,...,DEPTH-1,0. Each accepted allocation advances `alloc_tag_o` by one. With DEPTH loads outstanding, `alloc_ready_o` is 0 and a further allocation request changes nothing.
- R3: `retire_ok_o` is 1 exactly when the oldest outstanding load has executed. An asserted `retire_i` frees that load. `retire_i` while `retire_ok_o` is 0 has no effect.
- R4: A violation is flagged when all three of these happen in order: a younger load executes; a snoop then hits its line; an older load to the same line then executes. In the cycle after the older load's execute, `flush_o` is 1 for exactly one cycle, and `flush_tag_o` is the older load's tag.
- R5: No flush is raised in any of these cases: the snoop came before the younger load executed; the snoop hit a different line; the snoop arrives in the same cycle as the older load's execute.
- R6: Lines are 2^LINE_OFF bytes (64 by default). Address bits below LINE_OFF are ignored in every comparison.
- R7: No flush is raised when the older load executes to a different line from the snooped younger load.
- R8: A flush frees every slot from `flush_tag_o` to the tail. In the flush cycle, `alloc_tag_o` equals `flush_tag_o`, and loads older than the restart tag stay queued and can still retire.
- R9: When several execute ports flag a violation in the same cycle, the oldest offending load is reported.
- R10: The snoop mark of a slot is cleared when the slot is freed, so a reused slot starts unmarked.
- R11: An execute report for a slot that is not allocated, or that has already executed, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid_i | input | 1 | Request a slot for a new load |
| alloc_ready_o | output | 1 | A slot is free |
| alloc_tag_o | output | TAG_W | Tag the next allocation receives |
| exec_valid_i | input | N_EXEC | Per execute port: a load executed this cycle |
| exec_tag_i | input | N_EXEC*TAG_W | Per port: tag of the executing load (port p at bits p*TAG_W) |
| exec_addr_i | input | N_EXEC*ADDR_W | Per port: address read (port p at bits p*ADDR_W) |
| snoop_valid_i | input | 1 | Remote invalidation this cycle |
| snoop_addr_i | input | ADDR_W | Invalidated address |
| retire_i | input | 1 | Retire the oldest load |
| retire_ok_o | output | 1 | The oldest load may retire |
| flush_o | output | 1 | One-cycle restart request |
| flush_tag_o | output | TAG_W | Tag of the load to restart from |

## Verification
A slot whose executed or snoop flag is wrong shows up in one of two ways. A flush is missed, or a spurious flush appears, in the cycle after the older load's execute. Alternatively, `retire_ok_o` takes the wrong value as soon as that slot becomes the oldest. Head and tail pointer faults appear on `alloc_tag_o` and `alloc_ready_o` in the cycle after the allocation, retire or flush that moved them. For that reason, each scenario drains or refills the queue and watches the tag sequence and the retire permission, not the flush pulse alone.

// File: rtl/lq_pkg.sv
// Shared defaults for the load ordering monitor.
// Assumes: the queue depth is a power of two.
package lq_pkg;
    localparam int unsigned LQ_DEPTH_DEF    = 8;
    localparam int unsigned LQ_ADDR_W_DEF   = 32;
    localparam int unsigned LQ_LINE_OFF_DEF = 6;
    localparam int unsigned LQ_N_EXEC_DEF   = 2;
endpackage

// File: rtl/lq_entry_array.sv
// Per-slot state for the load queue.
// Each slot holds: a valid flag, an executed flag, a snoop mark and the address read.
// Assumes: allocation never targets a live slot, and the caller suppresses
// allocation in a flush cycle. A flush clears every slot whose distance from
// the head is at least that of the restart slot.
module lq_entry_array
    import lq_pkg::*;
#(
    parameter int unsigned DEPTH    = LQ_DEPTH_DEF,
    parameter int unsigned TAG_W    = $clog2(LQ_DEPTH_DEF),
    parameter int unsigned ADDR_W   = LQ_ADDR_W_DEF,
    parameter int unsigned LINE_OFF = LQ_LINE_OFF_DEF,
    parameter int unsigned N_EXEC   = LQ_N_EXEC_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_en,
    input  logic [TAG_W-1:0]           alloc_idx,
    input  logic [N_EXEC-1:0]          exec_en,
    input  logic [N_EXEC*TAG_W-1:0]    exec_tag,
    input  logic [N_EXEC*ADDR_W-1:0]   exec_addr,
    input  logic                       snoop_en,
    input  logic [ADDR_W-1:0]          snoop_addr,
    input  logic                       retire_en,
    input  logic [TAG_W-1:0]           head_idx,
    input  logic                       flush_en,
    input  logic [TAG_W-1:0]           flush_idx,
    output logic [DEPTH-1:0]           valid_o,
    output logic [DEPTH-1:0]           done_o,
    output logic [DEPTH-1:0]           snooped_o,
    output logic [DEPTH*ADDR_W-1:0]    addr_o
);
    localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << LINE_OFF;

    logic [TAG_W-1:0] flush_age;
    assign flush_age = flush_idx - head_idx;

    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        localparam logic [TAG_W-1:0] SLOT = TAG_W'(j);

        logic              v_q, d_q, s_q;
        logic [ADDR_W-1:0] a_q;
        logic              take;
        logic [ADDR_W-1:0] take_addr;
        logic [TAG_W-1:0]  slot_age;
        logic              kill;
        logic              snp_hit;

        // Pick the execute port addressing this slot; the lowest port wins.
        always_comb begin
            take      = 1'b0;
            take_addr = a_q;
            for (int p = N_EXEC - 1; p >= 0; p--) begin
                if (exec_en[p] && (exec_tag[p*TAG_W +: TAG_W] == SLOT)) begin
                    take      = v_q && !d_q;
                    take_addr = exec_addr[p*ADDR_W +: ADDR_W];
                end
            end
        end

        assign slot_age = SLOT - head_idx;
        assign kill     = flush_en && (slot_age >= flush_age);
        assign snp_hit  = snoop_en && v_q && d_q &&
                          (((a_q ^ snoop_addr) & LINE_MASK) == '0);

        // Slot lifecycle: free, allocated, executed, marked by snoop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                s_q <= 1'b0;
                a_q <= '0;
            end else if (kill) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                s_q <= 1'b0;
            end else if (alloc_en && (alloc_idx == SLOT)) begin
                v_q <= 1'b1;
                d_q <= 1'b0;
                s_q <= 1'b0;
            end else if (retire_en && (head_idx == SLOT)) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                s_q <= 1'b0;
            end else begin
                if (take) begin
                    d_q <= 1'b1;
                    a_q <= take_addr;
                end
                if (snp_hit) begin
                    s_q <= 1'b1;
                end
            end
        end

        assign valid_o[j]                 = v_q;
        assign done_o[j]                  = d_q;
        assign snooped_o[j]               = s_q;
        assign addr_o[j*ADDR_W +: ADDR_W] = a_q;
    end
endmodule

// File: rtl/lq_violation_check.sv
// Ordering check for one execute port.
// It flags when the executing load is live and not yet executed, and some
// younger slot has executed, been marked by a snoop and holds the same line.
// It also reports the executing load's distance from the head.
// Assumes: ages are taken modulo DEPTH relative to the head slot.
module lq_violation_check
    import lq_pkg::*;
#(
    parameter int unsigned DEPTH    = LQ_DEPTH_DEF,
    parameter int unsigned TAG_W    = $clog2(LQ_DEPTH_DEF),
    parameter int unsigned ADDR_W   = LQ_ADDR_W_DEF,
    parameter int unsigned LINE_OFF = LQ_LINE_OFF_DEF
) (
    input  logic                    exec_en,
    input  logic [TAG_W-1:0]        exec_tag,
    input  logic [ADDR_W-1:0]       exec_addr,
    input  logic [TAG_W-1:0]        head_idx,
    input  logic [DEPTH-1:0]        valid,
    input  logic [DEPTH-1:0]        done,
    input  logic [DEPTH-1:0]        snooped,
    input  logic [DEPTH*ADDR_W-1:0] addr,
    output logic                    hit,
    output logic [TAG_W-1:0]        age
);
    localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << LINE_OFF;

    logic [DEPTH-1:0] younger_stale;
    logic             qualified;

    assign age       = exec_tag - head_idx;
    assign qualified = exec_en && valid[exec_tag] && !done[exec_tag];

    for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
        logic [TAG_W-1:0] yage;
        assign yage = TAG_W'(j) - head_idx;
        assign younger_stale[j] = valid[j] && done[j] && snooped[j] && (yage > age) &&
            (((addr[j*ADDR_W +: ADDR_W] ^ exec_addr) & LINE_MASK) == '0);
    end

    assign hit = qualified && (|younger_stale);
endmodule

// File: rtl/lq_flush_select.sv
// Chooses the oldest offending load among the execute ports and registers
// the one-cycle restart request.
// Assumes: port results arrive in the same cycle. On equal ages the lower port wins.
module lq_flush_select
    import lq_pkg::*;
#(
    parameter int unsigned N_EXEC = LQ_N_EXEC_DEF,
    parameter int unsigned TAG_W  = $clog2(LQ_DEPTH_DEF)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_EXEC-1:0]       hit,
    input  logic [N_EXEC*TAG_W-1:0] ages,
    input  logic [N_EXEC*TAG_W-1:0] tags,
    output logic                    viol_o,
    output logic [TAG_W-1:0]        win_tag_o,
    output logic [TAG_W-1:0]        win_age_o,
    output logic                    flush_o,
    output logic [TAG_W-1:0]        flush_tag_o
);
    // Oldest-first reduction across the ports.
    always_comb begin
        viol_o    = 1'b0;
        win_tag_o = '0;
        win_age_o = '0;
        for (int p = 0; p < N_EXEC; p++) begin
            if (hit[p] && (!viol_o || (ages[p*TAG_W +: TAG_W] < win_age_o))) begin
                viol_o    = 1'b1;
                win_tag_o = tags[p*TAG_W +: TAG_W];
                win_age_o = ages[p*TAG_W +: TAG_W];
            end
        end
    end

    // Restart request register: a pulse of one cycle per detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_o     <= 1'b0;
            flush_tag_o <= '0;
        end else begin
            flush_o <= viol_o;
            if (viol_o) begin
                flush_tag_o <= win_tag_o;
            end
        end
    end
endmodule

// File: rtl/lq_order_monitor.sv
// Load queue that enforces processor ordering for loads executing out of order.
// Slots are a ring addressed by head and tail pointers, each with a wrap bit.
// Loads retire from the head only after they have executed. A detected violation
// truncates the tail back to the offending load and raises a restart request.
// Assumes: the core tags each load with alloc_tag_o, reports execution with the
// same tag, and treats an allocation in a detecting cycle as discarded.
module lq_order_monitor
    import lq_pkg::*;
#(
    parameter int unsigned DEPTH    = LQ_DEPTH_DEF,
    parameter int unsigned ADDR_W   = LQ_ADDR_W_DEF,
    parameter int unsigned LINE_OFF = LQ_LINE_OFF_DEF,
    parameter int unsigned N_EXEC   = LQ_N_EXEC_DEF,
    localparam int unsigned TAG_W   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid_i,
    output logic                     alloc_ready_o,
    output logic [TAG_W-1:0]         alloc_tag_o,
    input  logic [N_EXEC-1:0]        exec_valid_i,
    input  logic [N_EXEC*TAG_W-1:0]  exec_tag_i,
    input  logic [N_EXEC*ADDR_W-1:0] exec_addr_i,
    input  logic                     snoop_valid_i,
    input  logic [ADDR_W-1:0]        snoop_addr_i,
    input  logic                     retire_i,
    output logic                     retire_ok_o,
    output logic                     flush_o,
    output logic [TAG_W-1:0]         flush_tag_o
);
    localparam int unsigned PTR_W = TAG_W + 1;

    logic [PTR_W-1:0]        head_q, tail_q, occupancy;
    logic [TAG_W-1:0]        head_idx;
    logic                    full;
    logic                    alloc_en, retire_en;
    logic [DEPTH-1:0]        valid_w, done_w, snooped_w;
    logic [DEPTH*ADDR_W-1:0] addr_w;
    logic [N_EXEC-1:0]       port_hit;
    logic [N_EXEC*TAG_W-1:0] port_age;
    logic                    viol_any;
    logic [TAG_W-1:0]        win_tag, win_age;

    assign occupancy     = tail_q - head_q;
    assign full          = occupancy[TAG_W];
    assign head_idx      = head_q[TAG_W-1:0];
    assign alloc_ready_o = !full;
    assign alloc_tag_o   = tail_q[TAG_W-1:0];
    assign retire_ok_o   = valid_w[head_idx] && done_w[head_idx];
    assign alloc_en      = alloc_valid_i && !full && !viol_any;
    assign retire_en     = retire_i && retire_ok_o;

    // Ring pointers: the head moves on retire; the tail moves on allocate or is cut back by a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + PTR_W'(retire_en);
            if (viol_any) begin
                tail_q <= head_q + {1'b0, win_age};
            end else begin
                tail_q <= tail_q + PTR_W'(alloc_en);
            end
        end
    end

    lq_entry_array #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
        .LINE_OFF(LINE_OFF), .N_EXEC(N_EXEC)
    ) slots_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_idx  (tail_q[TAG_W-1:0]),
        .exec_en    (exec_valid_i),
        .exec_tag   (exec_tag_i),
        .exec_addr  (exec_addr_i),
        .snoop_en   (snoop_valid_i),
        .snoop_addr (snoop_addr_i),
        .retire_en  (retire_en),
        .head_idx   (head_idx),
        .flush_en   (viol_any),
        .flush_idx  (win_tag),
        .valid_o    (valid_w),
        .done_o     (done_w),
        .snooped_o  (snooped_w),
        .addr_o     (addr_w)
    );

    for (genvar p = 0; p < N_EXEC; p++) begin : g_port
        lq_violation_check #(
            .DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF)
        ) check_i (
            .exec_en   (exec_valid_i[p]),
            .exec_tag  (exec_tag_i[p*TAG_W +: TAG_W]),
            .exec_addr (exec_addr_i[p*ADDR_W +: ADDR_W]),
            .head_idx  (head_idx),
            .valid     (valid_w),
            .done      (done_w),
            .snooped   (snooped_w),
            .addr      (addr_w),
            .hit       (port_hit[p]),
            .age       (port_age[p*TAG_W +: TAG_W])
        );
    end

    lq_flush_select #(
        .N_EXEC(N_EXEC), .TAG_W(TAG_W)
    ) select_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (port_hit),
        .ages        (port_age),
        .tags        (exec_tag_i),
        .viol_o      (viol_any),
        .win_tag_o   (win_tag),
        .win_age_o   (win_age),
        .flush_o     (flush_o),
        .flush_tag_o (flush_tag_o)
    );
endmodule

// File: rtl/lq_order_checker.sv
// Temporal properties of the load ordering monitor, bound to its top.
// Assumes: reset is synchronous and active low.
module lq_order_checker #(
    parameter int unsigned N_EXEC = 2,
    parameter int unsigned TAG_W  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_EXEC-1:0]       exec_valid_i,
    input logic [N_EXEC*TAG_W-1:0] exec_tag_i,
    input logic                    snoop_valid_i,
    input logic                    retire_i,
    input logic                    alloc_ready_o,
    input logic [TAG_W-1:0]        alloc_tag_o,
    input logic                    retire_ok_o,
    input logic                    flush_o,
    input logic [TAG_W-1:0]        flush_tag_o,
    input logic                    viol_any
);
    logic [N_EXEC-1:0]       prev_valid;
    logic [N_EXEC*TAG_W-1:0] prev_tags;
    logic                    snoop_seen_q1, snoop_seen_q2;
    logic                    tag_seen;

    // Remember the previous cycle's execute ports and whether any snoop has occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid    <= '0;
            prev_tags     <= '0;
            snoop_seen_q1 <= 1'b0;
            snoop_seen_q2 <= 1'b0;
        end else begin
            prev_valid    <= exec_valid_i;
            prev_tags     <= exec_tag_i;
            snoop_seen_q1 <= snoop_seen_q1 | snoop_valid_i;
            snoop_seen_q2 <= snoop_seen_q1;
        end
    end

    // Did the previous cycle execute the tag now being restarted?
    always_comb begin
        tag_seen = 1'b0;
        for (int p = 0; p < N_EXEC; p++) begin
            if (prev_valid[p] && (prev_tags[p*TAG_W +: TAG_W] == flush_tag_o)) begin
                tag_seen = 1'b1;
            end
        end
    end

    a_r4_flush_names_executed_load: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> tag_seen);

    a_r5_flush_needs_earlier_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> snoop_seen_q2);

    a_r8_flush_cuts_tail: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (alloc_tag_o == flush_tag_o));

    a_r2_full_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready_o && !viol_any) |=> (alloc_tag_o == $past(alloc_tag_o)));

    a_r3_ok_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_ok_o && !retire_i) |=> retire_ok_o);
endmodule

bind lq_order_monitor lq_order_checker #(.N_EXEC(N_EXEC), .TAG_W(TAG_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .exec_valid_i  (exec_valid_i),
    .exec_tag_i    (exec_tag_i),
    .snoop_valid_i (snoop_valid_i),
    .retire_i      (retire_i),
    .alloc_ready_o (alloc_ready_o),
    .alloc_tag_o   (alloc_tag_o),
    .retire_ok_o   (retire_ok_o),
    .flush_o       (flush_o),
    .flush_tag_o   (flush_tag_o),
    .viol_any      (viol_any)
);

// File: tb/lq_order_monitor_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module lq_order_monitor_tb_top;
    localparam int TAG_W  = 3;
    localparam int ADDR_W = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                alloc_valid_i = 1'b0;
    logic                alloc_ready_o;
    logic [TAG_W-1:0]    alloc_tag_o;
    logic [1:0]          exec_valid_i = '0;
    logic [2*TAG_W-1:0]  exec_tag_i = '0;
    logic [2*ADDR_W-1:0] exec_addr_i = '0;
    logic                snoop_valid_i = 1'b0;
    logic [ADDR_W-1:0]   snoop_addr_i = '0;
    logic                retire_i = 1'b0;
    logic                retire_ok_o;
    logic                flush_o;
    logic [TAG_W-1:0]    flush_tag_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    lq_order_monitor dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid_i), .alloc_ready_o(alloc_ready_o), .alloc_tag_o(alloc_tag_o),
        .exec_valid_i(exec_valid_i), .exec_tag_i(exec_tag_i), .exec_addr_i(exec_addr_i),
        .snoop_valid_i(snoop_valid_i), .snoop_addr_i(snoop_addr_i),
        .retire_i(retire_i), .retire_ok_o(retire_ok_o),
        .flush_o(flush_o), .flush_tag_o(flush_tag_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one clock; outputs are stable 1 ns after the edge and pulse inputs drop.
    task automatic step();
        @(posedge clk);
        #1;
        alloc_valid_i = 1'b0;
        exec_valid_i  = '0;
        snoop_valid_i = 1'b0;
        retire_i      = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic alloc_n(input int n);
        for (int i = 0; i < n; i++) begin
            alloc_valid_i = 1'b1;
            step();
        end
    endtask

    task automatic set_exec(input int port, input int tag, input logic [ADDR_W-1:0] addr);
        exec_valid_i[port]                 = 1'b1;
        exec_tag_i[port*TAG_W +: TAG_W]    = TAG_W'(tag);
        exec_addr_i[port*ADDR_W +: ADDR_W] = addr;
    endtask

    task automatic exec1(input int tag, input logic [ADDR_W-1:0] addr);
        set_exec(0, tag, addr);
        step();
    endtask

    task automatic snoop(input logic [ADDR_W-1:0] addr);
        snoop_valid_i = 1'b1;
        snoop_addr_i  = addr;
        step();
    endtask

    task automatic retire1();
        retire_i = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 ready", alloc_ready_o, 1);
        chk("R1 tag", alloc_tag_o, 0);
        chk("R1 retire_ok", retire_ok_o, 0);
        chk("R1 flush", flush_o, 0);
    endtask

    task automatic t_alloc_ring();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            chk("R2 ring tag", alloc_tag_o, i);
            alloc_n(1);
        end
        chk("R2 full ready", alloc_ready_o, 0);
        alloc_n(1);
        chk("R2 full tag held", alloc_tag_o, 0);
        exec1(0, 32'h100);
        retire1();
        chk("R2 ready after retire", alloc_ready_o, 1);
        alloc_n(1);
        chk("R2 wrap tag", alloc_tag_o, 1);
        chk("R2 full again", alloc_ready_o, 0);
    endtask

    task automatic t_retire();
        do_reset();
        alloc_n(2);
        chk("R3 unexecuted head", retire_ok_o, 0);
        exec1(1, 32'h200);
        chk("R3 younger only", retire_ok_o, 0);
        retire1();
        exec1(0, 32'h300);
        chk("R3 head executed", retire_ok_o, 1);
        retire1();
        chk("R3 second ok", retire_ok_o, 1);
        retire1();
        chk("R3 drained", retire_ok_o, 0);
        chk("R3 tag after drain", alloc_tag_o, 2);
    endtask

    task automatic t_basic_violation();
        do_reset();
        alloc_n(4);
        exec1(2, 32'h1000);
        snoop(32'h1000);
        exec1(1, 32'h1008);
        chk("R4 flush", flush_o, 1);
        chk("R4 flush tag", flush_tag_o, 1);
        chk("R8 tail cut", alloc_tag_o, 1);
        step();
        chk("R4 one-cycle pulse", flush_o, 0);
        chk("R8 head kept", retire_ok_o, 0);
        exec1(0, 32'h3000);
        chk("R8 head retirable", retire_ok_o, 1);
        retire1();
        chk("R8 rest discarded", retire_ok_o, 0);
        chk("R8 empty ready", alloc_ready_o, 1);
        alloc_n(1);
        chk("R8 realloc tag", alloc_tag_o, 2);
    endtask

    task automatic t_no_violation();
        do_reset();
        alloc_n(2);
        snoop(32'h5000);
        exec1(1, 32'h5000);
        exec1(0, 32'h5000);
        chk("R5 snoop before younger", flush_o, 0);
        chk("R5 entries intact", retire_ok_o, 1);
        do_reset();
        alloc_n(2);
        exec1(1, 32'h5000);
        snoop(32'h6000);
        exec1(0, 32'h5000);
        chk("R5 other line", flush_o, 0);
        do_reset();
        alloc_n(2);
        exec1(1, 32'h5000);
        snoop_valid_i = 1'b1;
        snoop_addr_i  = 32'h5000;
        set_exec(0, 0, 32'h5000);
        step();
        chk("R5 same-cycle snoop", flush_o, 0);
        step();
        chk("R5 same-cycle later", flush_o, 0);
    endtask

    task automatic t_line();
        do_reset();
        alloc_n(2);
        exec1(1, 32'h2004);
        snoop(32'h203F);
        exec1(0, 32'h2010);
        chk("R6 low bits ignored", flush_o, 1);
        chk("R6 tag", flush_tag_o, 0);
        do_reset();
        alloc_n(2);
        exec1(1, 32'h2004);
        snoop(32'h2040);
        exec1(0, 32'h2010);
        chk("R6 next line", flush_o, 0);
    endtask

    task automatic t_diff_line();
        do_reset();
        alloc_n(2);
        exec1(1, 32'h7000);
        snoop(32'h7000);
        exec1(0, 32'h8000);
        chk("R7 older other line", flush_o, 0);
        chk("R7 retire_ok", retire_ok_o, 1);
    endtask

    task automatic t_two_ports();
        do_reset();
        alloc_n(6);
        exec1(3, 32'hA000);
        exec1(5, 32'hB000);
        snoop(32'hA000);
        snoop(32'hB000);
        set_exec(0, 4, 32'hB000);
        set_exec(1, 2, 32'hA000);
        step();
        chk("R9 flush", flush_o, 1);
        chk("R9 oldest tag", flush_tag_o, 2);
        chk("R9 tail", alloc_tag_o, 2);
    endtask

    task automatic t_stale_mark();
        do_reset();
        alloc_n(1);
        exec1(0, 32'hC000);
        snoop(32'hC000);
        retire1();
        alloc_n(8);
        exec1(0, 32'hC000);
        exec1(1, 32'hC000);
        chk("R10 reused slot unmarked", flush_o, 0);
        chk("R10 head ok", retire_ok_o, 1);
    endtask

    task automatic t_ignored_exec();
        do_reset();
        alloc_n(2);
        exec1(2, 32'hD000);
        alloc_n(1);
        exec1(0, 32'hD000);
        exec1(1, 32'hD000);
        retire1();
        retire1();
        chk("R11 unallocated exec ignored", retire_ok_o, 0);
        do_reset();
        alloc_n(2);
        exec1(1, 32'hE000);
        snoop(32'hE000);
        exec1(1, 32'hF000);
        exec1(0, 32'hE000);
        chk("R11 re-exec ignored", flush_o, 1);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_alloc_ring();
        t_retire();
        t_basic_violation();
        t_no_violation();
        t_line();
        t_diff_line();
        t_two_ports();
        t_stale_mark();
        t_ignored_exec();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule